// File: doc/BRIEF.md
# Ring-Rotation Dense Matrix Multiplier

This block multiplies two square N×N matrices of signed 16-bit integers and keeps the product in local result storage. The work is spread over P processing elements that form a one-way ring. Element i keeps one horizontal slice of A, made of N/P consecutive rows. Each element starts with the vertical slice of B that has the same index. In every phase, each element works out the block of C where its row slice of A meets the column slice of B it holds at that moment. Each element runs one multiply-accumulate per cycle. During the same phase, the element copies its B slice into the spare bank of the next element on the ring. At the phase boundary every element swaps banks. After P phases, every element has seen every B slice, and the whole of C is complete.

A host first writes A and B one element at a time through a load port. It then pulses start and waits for done. It reads C back through an address-driven read port. The B slices travel around the whole ring and end up back where they started, so the host can start a second multiplication with a new A and the B it already loaded.

Top module: `ring_mm_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy and done are both 0.
- R2: With busy low, a load writes loadData into A[loadRow][loadCol] when loadSel is 0 and into B[loadRow][loadCol] when loadSel is 1.
- R3: After a run, C[r][c] equals the exact sum over k of A[r][k]·B[k][c], computed as a signed value in a 40-bit accumulator. Magnitudes beyond 32 bits must not be truncated.
- R4: A start pulse seen while idle raises busy in the next cycle. Busy stays high for exactly N³/P+1 cycles, and done rises in the cycle in which busy falls.
- R5: A start pulse seen while busy is high has no effect on the run length or on the results.
- R6: Loads presented while busy is high are ignored. The results of the run, and the operands used by later runs, are unchanged.
- R7: Done stays high until the next accepted start, which clears it. Done and busy are never high together.
- R8: After a run, every B column slice is back in its home element. A new run with only A reloaded therefore multiplies by the same B.
- R9: rdData presents C[rdRow][rdCol] combinationally. It holds steady while the block is idle and the read address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication (accepted only when idle) |
| loadEn | input | 1 | Write one operand element |
| loadSel | input | 1 | 0 selects A, 1 selects B |
| loadRow | input | $clog2(N) | Operand row index |
| loadCol | input | $clog2(N) | Operand column index |
| loadData | input | 16 | Signed operand value |
| rdRow | input | $clog2(N) | Result row index |
| rdCol | input | $clog2(N) | Result column index |
| rdData | output | 40 | Signed result C[rdRow][rdCol] |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | Results valid since the last run |

## Verification
The bench builds the default configuration: four elements and 8×8 matrices. Each element therefore holds two rows and two columns, and a run takes four phases of 32 cycles each. With this size, all 64 entries of C can be compared after every run. The ring index wraps from the last element back to element 0. Because P is even, the bank parity comes back to its starting value, which is what lets a second run reuse the loaded B. Extreme operands push every sum to 2^33, above the 32-bit range, so an accumulator that is too narrow shows up. Start pulses and loads injected in the middle of a run exercise the rules for ignoring them while busy.

// File: rtl/ring_mm_pkg.sv
package ring_mm_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RUN   = 2'd1,
    S_FLUSH = 2'd2
  } mmState_t;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic issue;  // a MAC operand pair is presented this cycle
    logic first;  // first term of a dot product
    logic last;   // final term of a dot product
    logic xfer;   // copy one B word to the neighbour's spare bank
    logic swap;   // end of phase: exchange active and spare banks
  } mmStrobe_t;

endpackage

// File: rtl/ring_mm_ctrl.sv
module ring_mm_ctrl
  import ring_mm_pkg::*;
#(
  parameter int P = 4,
  parameter int N = 8,
  localparam int NB  = N / P,
  localparam int IW  = (N > 1) ? $clog2(N) : 1,
  localparam int NBW = (NB > 1) ? $clog2(NB) : 1,
  localparam int PW  = (P > 1) ? $clog2(P) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  output logic           busy,
  output logic           done,
  output mmStrobe_t      strobe,
  output logic [NBW-1:0] rowIdx,
  output logic [NBW-1:0] colIdx,
  output logic [IW-1:0]  kIdx,
  output logic [IW-1:0]  xRow,
  output logic [NBW-1:0] xCol,
  output logic [PW-1:0]  phase
);

  mmState_t state;
  logic     xActive;
  logic     lastK, lastCol, lastRow, phaseEnd, lastPhase, xLast;

  assign lastK     = (kIdx == IW'(N - 1));
  assign lastCol   = (colIdx == NBW'(NB - 1));
  assign lastRow   = (rowIdx == NBW'(NB - 1));
  assign phaseEnd  = lastK && lastCol && lastRow;
  assign lastPhase = (phase == PW'(P - 1));
  assign xLast     = (xRow == IW'(N - 1)) && (xCol == NBW'(NB - 1));

  assign busy = (state != S_IDLE);

  always_comb begin
    strobe.issue = (state == S_RUN);
    strobe.first = (state == S_RUN) && (kIdx == '0);
    strobe.last  = (state == S_RUN) && lastK;
    strobe.xfer  = (state == S_RUN) && xActive;
    strobe.swap  = (state == S_RUN) && phaseEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      xActive <= 1'b0;
      rowIdx  <= '0;
      colIdx  <= '0;
      kIdx    <= '0;
      xRow    <= '0;
      xCol    <= '0;
      phase   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_RUN;
            done    <= 1'b0;
            xActive <= 1'b1;
            rowIdx  <= '0;
            colIdx  <= '0;
            kIdx    <= '0;
            xRow    <= '0;
            xCol    <= '0;
            phase   <= '0;
          end
        end
        S_RUN: begin
          // dot-product walk: k innermost, then column, then row
          if (lastK) begin
            kIdx <= '0;
            if (lastCol) begin
              colIdx <= '0;
              if (lastRow) rowIdx <= '0;
              else         rowIdx <= rowIdx + 1'b1;
            end else begin
              colIdx <= colIdx + 1'b1;
            end
          end else begin
            kIdx <= kIdx + 1'b1;
          end
          // ring transfer walk, finishes well inside a phase
          if (xActive) begin
            if (xLast) begin
              xActive <= 1'b0;
            end else if (xCol == NBW'(NB - 1)) begin
              xCol <= '0;
              xRow <= xRow + 1'b1;
            end else begin
              xCol <= xCol + 1'b1;
            end
          end
          if (phaseEnd) begin
            xRow <= '0;
            xCol <= '0;
            if (lastPhase) begin
              state   <= S_FLUSH;
              phase   <= '0;
              xActive <= 1'b0;
            end else begin
              phase   <= phase + 1'b1;
              xActive <= 1'b1;
            end
          end
        end
        S_FLUSH: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ring_mm_datapath.sv
module ring_mm_datapath
  import ring_mm_pkg::*;
#(
  parameter int P  = 4,
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int AW = 40,
  localparam int NB  = N / P,
  localparam int IW  = (N > 1) ? $clog2(N) : 1,
  localparam int NBW = (NB > 1) ? $clog2(NB) : 1,
  localparam int PW  = (P > 1) ? $clog2(P) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           busy,
  input  logic           loadEn,
  input  logic           loadSel,
  input  logic [IW-1:0]  loadRow,
  input  logic [IW-1:0]  loadCol,
  input  logic [DW-1:0]  loadData,
  input  mmStrobe_t      strobe,
  input  logic [NBW-1:0] rowIdx,
  input  logic [NBW-1:0] colIdx,
  input  logic [IW-1:0]  kIdx,
  input  logic [IW-1:0]  xRow,
  input  logic [NBW-1:0] xCol,
  input  logic [PW-1:0]  phase,
  input  logic [IW-1:0]  rdRow,
  input  logic [IW-1:0]  rdCol,
  output logic [AW-1:0]  rdData
);

  logic                   curBank;
  logic [P-1:0][DW-1:0]   xferWord;
  logic [P-1:0][AW-1:0]   rdWord;
  logic                   loadOk;
  logic [NBW-1:0]         ldRowLoc, ldColLoc, rdRowLoc;
  logic [PW-1:0]          rdPe;

  assign loadOk   = loadEn && !busy;
  assign ldRowLoc = NBW'(int'(loadRow) % NB);
  assign ldColLoc = NBW'(int'(loadCol) % NB);
  assign rdRowLoc = NBW'(int'(rdRow) % NB);
  assign rdPe     = PW'(int'(rdRow) / NB);
  assign rdData   = rdWord[rdPe];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            curBank <= 1'b0;
    else if (strobe.swap) curBank <= ~curBank;
  end

  for (genvar g = 0; g < P; g++) begin : g_pe
    localparam int SRC = (g + P - 1) % P;

    logic signed [DW-1:0]   aMem [NB][N];
    logic signed [DW-1:0]   bMem [2][N][NB];
    logic signed [AW-1:0]   cMem [NB][N];
    logic signed [DW-1:0]   aOp, bOp;
    logic signed [2*DW-1:0] prod, prodQ;
    logic signed [AW-1:0]   accQ, sum;
    logic                   validQ, firstQ, lastQ;
    logic [NBW-1:0]         rowQ;
    logic [IW-1:0]          gCol, colQ;

    assign aOp  = aMem[rowIdx][kIdx];
    assign bOp  = bMem[curBank][kIdx][colIdx];
    assign prod = aOp * bOp;
    // column slice held in this phase arrived from g - phase around the ring
    assign gCol = IW'(((g + P - int'(phase)) % P) * NB + int'(colIdx));
    assign sum  = (firstQ ? '0 : accQ) + {{(AW-2*DW){prodQ[2*DW-1]}}, prodQ};

    assign xferWord[g] = bMem[curBank][xRow][xCol];
    assign rdWord[g]   = cMem[rdRowLoc][rdCol];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= 1'b0;
        firstQ <= 1'b0;
        lastQ  <= 1'b0;
        prodQ  <= '0;
        rowQ   <= '0;
        colQ   <= '0;
        accQ   <= '0;
      end else begin
        validQ <= strobe.issue;
        firstQ <= strobe.first;
        lastQ  <= strobe.last;
        prodQ  <= prod;
        rowQ   <= rowIdx;
        colQ   <= gCol;
        if (validQ) accQ <= sum;
      end
    end

    always_ff @(posedge clk) begin
      if (loadOk && !loadSel && (int'(loadRow) / NB == g))
        aMem[ldRowLoc][loadCol] <= loadData;
      if (loadOk && loadSel && (int'(loadCol) / NB == g))
        bMem[curBank][loadRow][ldColLoc] <= loadData;
      if (strobe.xfer)
        bMem[~curBank][xRow][xCol] <= xferWord[SRC];
      if (validQ && lastQ)
        cMem[rowQ][colQ] <= sum;
    end
  end

endmodule

// File: rtl/ring_mm_top.sv
module ring_mm_top
  import ring_mm_pkg::*;
#(
  parameter int P  = 4,
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int AW = 40,
  localparam int NB  = N / P,
  localparam int IW  = (N > 1) ? $clog2(N) : 1,
  localparam int NBW = (NB > 1) ? $clog2(NB) : 1,
  localparam int PW  = (P > 1) ? $clog2(P) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          loadEn,
  input  logic          loadSel,
  input  logic [IW-1:0] loadRow,
  input  logic [IW-1:0] loadCol,
  input  logic [DW-1:0] loadData,
  input  logic [IW-1:0] rdRow,
  input  logic [IW-1:0] rdCol,
  output logic [AW-1:0] rdData,
  output logic          busy,
  output logic          done
);

  mmStrobe_t      strobe;
  logic [NBW-1:0] rowIdx, colIdx, xCol;
  logic [IW-1:0]  kIdx, xRow;
  logic [PW-1:0]  phase;

  ring_mm_ctrl #(.P(P), .N(N)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .strobe(strobe), .rowIdx(rowIdx), .colIdx(colIdx), .kIdx(kIdx),
    .xRow(xRow), .xCol(xCol), .phase(phase)
  );

  ring_mm_datapath #(.P(P), .N(N), .DW(DW), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .busy(busy), .loadEn(loadEn), .loadSel(loadSel),
    .loadRow(loadRow), .loadCol(loadCol), .loadData(loadData),
    .strobe(strobe), .rowIdx(rowIdx), .colIdx(colIdx), .kIdx(kIdx),
    .xRow(xRow), .xCol(xCol), .phase(phase),
    .rdRow(rdRow), .rdCol(rdCol), .rdData(rdData)
  );

endmodule

// File: rtl/ring_mm_chk.sv
module ring_mm_chk #(
  parameter int N  = 8,
  parameter int P  = 4,
  parameter int AW = 40,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int RUN_LEN = (N * N * N) / P + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [IW-1:0] rdRow,
  input logic [IW-1:0] rdCol,
  input logic [AW-1:0] rdData
);

  int busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= 0;
    else if (busy) busyCnt <= busyCnt + 1;
    else           busyCnt <= 0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!busy && !done));

  // R4
  run_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == RUN_LEN));

  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R9
  read_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(done) && $stable(rdRow) && $stable(rdCol)) |-> $stable(rdData));

endmodule

bind ring_mm_top ring_mm_chk #(.N(N), .P(P), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .rdRow(rdRow), .rdCol(rdCol), .rdData(rdData)
);

// File: tb/ring_mm_top_bench.sv
module ring_mm_top_bench;
  localparam int P  = 4;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int AW = 40;
  localparam int IW = $clog2(N);
  localparam int RUN_LEN = (N * N * N) / P + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          loadEn = 1'b0;
  logic          loadSel = 1'b0;
  logic [IW-1:0] loadRow = '0;
  logic [IW-1:0] loadCol = '0;
  logic [DW-1:0] loadData = '0;
  logic [IW-1:0] rdRow = '0;
  logic [IW-1:0] rdCol = '0;
  logic [AW-1:0] rdData;
  logic          busy, done;

  int checks = 0;
  int failures = 0;
  int seed = 32'h1234_5678;

  longint aM [N][N];
  longint bM [N][N];

  always #10 clk = ~clk;

  ring_mm_top #(.P(P), .N(N), .DW(DW), .AW(AW)) u_ring_mm_top (
    .clk(clk), .rstN(rstN), .start(start), .loadEn(loadEn), .loadSel(loadSel),
    .loadRow(loadRow), .loadCol(loadCol), .loadData(loadData),
    .rdRow(rdRow), .rdCol(rdCol), .rdData(rdData), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint nextVal();
    seed = seed * 1103515245 + 12345;
    return longint'($signed(seed[30:15]));
  endfunction

  task automatic loadOne(input bit sel, input int r, input int c, input longint v);
    @(negedge clk);
    loadEn = 1'b1; loadSel = sel;
    loadRow = IW'(r); loadCol = IW'(c); loadData = DW'(v);
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic loadA();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) loadOne(1'b0, r, c, aM[r][c]);
  endtask

  task automatic loadB();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) loadOne(1'b1, r, c, bM[r][c]);
  endtask

  // disturb: inject a start pulse and garbage loads in mid-run (R5, R6)
  task automatic runMult(input bit disturb);
    int cnt;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R4 busy after start", busy, 1);
    check(done == 1'b0, "R7 done cleared by start", done, 0);
    cnt = 0;
    while (cnt < RUN_LEN + 20) begin
      @(negedge clk);
      cnt++;
      if (disturb && cnt == 20) begin
        start = 1'b1; loadEn = 1'b1; loadSel = 1'b0;
        loadRow = '0; loadCol = '0; loadData = 16'h7777;
      end
      if (disturb && cnt == 22) begin
        loadSel = 1'b1; loadRow = IW'(3); loadCol = IW'(5); loadData = 16'h8001;
      end
      if (disturb && cnt == 25) begin
        start = 1'b0; loadEn = 1'b0;
      end
      if (done) break;
    end
    check(cnt == RUN_LEN, disturb ? "R5 run length with stray start" : "R4 run length",
          cnt, RUN_LEN);
    check(busy == 1'b0, "R4 busy low at done", busy, 0);
  endtask

  task automatic checkC(input string tag);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        longint exp = 0;
        for (int k = 0; k < N; k++) exp += aM[r][k] * bM[k][c];
        rdRow = IW'(r); rdCol = IW'(c);
        #1;
        check(longint'($signed(rdData)) == exp, tag, longint'($signed(rdData)), exp);
      end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint hold;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 idle after reset", {busy, done}, 0);

    // identity A, ramp B: C must equal B (R2 placement, R3)
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        aM[r][c] = (r == c) ? 1 : 0;
        bM[r][c] = r * N + c - 20;
      end
    loadA(); loadB();
    runMult(1'b0);
    checkC("R2 identity placement");

    // pseudo-random full-range operands (R3)
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        aM[r][c] = nextVal();
        bM[r][c] = nextVal();
      end
    loadA(); loadB();
    runMult(1'b0);
    checkC("R3 random operands");

    // done holds while idle, read is stable (R7, R9)
    rdRow = IW'(6); rdCol = IW'(1);
    #1 hold = longint'($signed(rdData));
    repeat (10) @(negedge clk);
    check(done == 1'b1, "R7 done holds", done, 1);
    check(longint'($signed(rdData)) == hold, "R9 read stable",
          longint'($signed(rdData)), hold);

    // new A only, B reused after a full ring rotation (R8)
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) aM[r][c] = nextVal();
    loadA();
    runMult(1'b0);
    checkC("R8 B reused");

    // stray start and loads during a run (R5, R6)
    runMult(1'b1);
    checkC("R6 loads ignored while busy");

    // extremes: sums of 2^30 terms reach 2^33 (R3)
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        aM[r][c] = -32768;
        bM[r][c] = -32768;
      end
    loadA(); loadB();
    runMult(1'b0);
    checkC("R3 max positive sum");

    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) bM[r][c] = 32767;
    loadB();
    runMult(1'b0);
    checkC("R3 max negative sum");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule